// File: doc/BRIEF.md
# I2C Register Slave with Strap-Selected Address

This block is the serial control port of a device. It listens on a two-wire bus. The bus has a clock line and an open-drain data line, and the block samples both with its own system clock. It answers to a seven-bit address. The upper six bits of that address are fixed by a parameter, and the lowest bit follows an external strap pin, so two devices can share one bus.

A write transaction carries a pointer byte and then any number of data bytes. The block acknowledges each of them. Each data byte appears as a one-cycle write strobe on a simple register port. A read transaction returns the register that the current pointer selects, starting right after the address byte. The top bit of the pointer byte turns on auto-increment, so one transaction can cover a run of consecutive registers.

The register storage sits outside the block. It sees `reg_addr` and `reg_wr_en` / `reg_wr_data`, and it returns `reg_rd_data` combinationally.

Top module: `i2c_ctl_slave`

## Requirements
- R1: While reset is active and directly after it, the data line is released (`sda_oe` = 0), no write strobe occurs, and the pointer is 0x00, so auto-increment is off and register 0 is selected.
- R2: A START followed by the address byte `{ADDR_HI, strap_i, rw}` (default ADDR_HI = 6'b001000) is acknowledged: the line is pulled low during the ninth clock. This holds for both strap levels.
- R3: An address byte whose upper seven bits differ from `{ADDR_HI, strap_i}` gets no ACK. The bytes that follow it get no ACK and cause no writes, until the next START.
- R4: In a write (rw = 0), the first byte after the address loads the 8-bit pointer. Pointer bit 7 is the auto-increment enable and bits 6:0 are the register index. Each later byte gives one single-cycle `reg_wr_en` pulse at `reg_addr` = pointer[6:0], and the block ACKs every byte.
- R5: With pointer bit 7 = 1, the register index advances by one after each data byte written or read. With bit 7 = 0 it stays the same.
- R6: In a read (rw = 1), the block shifts out `reg_rd_data` at the current pointer, MSB first, starting with the clock that follows the address ACK.
- R7: During a read, an ACK from the master (data low on the ninth clock) makes the block send the next byte. A NACK releases the line and ends the data phase.
- R8: A data fall while the clock is high is a START. A data rise while the clock is high is a STOP. A repeated START returns the block to address reception while keeping the pointer.
- R9: `sda_oe` changes only while the bus clock is low.
- R10: The pointer keeps its value from one transaction to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| strap_i | input | 1 | Strap level that selects the address LSB |
| reg_addr | output | 7 | Register index (pointer bits 6:0) |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 8 | Byte to write |
| reg_rd_data | input | 8 | Register content at `reg_addr` |

## Verification
A wrong byte count or kind state shows up within the next byte. An ACK arrives in the wrong clock, or a write is missing or lands at the wrong index, or read data appears shifted. A pointer that does not advance, or that advances when it should not, stays hidden until a later transaction reads it back through the bus, so the bench re-reads registers after every pointer change. If the block is still active after an address mismatch, it drives the line or writes during bytes that must be ignored. That becomes visible at the next ninth clock.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int PTR_W  = BYTE_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_WAIT,
        ST_ACK,
        ST_TX,
        ST_RACK,
        ST_RNEXT
    } state_e;

    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } kind_e;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES:0] scl;
        logic [STAGES:0] sda;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic  scl_now, scl_old, sda_now, sda_old;

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.scl = {pipe_q.scl[STAGES-1:0], scl_i};
        pipe_d.sda = {pipe_q.sda[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign scl_now   = pipe_q.scl[STAGES-1];
    assign scl_old   = pipe_q.scl[STAGES];
    assign sda_now   = pipe_q.sda[STAGES-1];
    assign sda_old   = pipe_q.sda[STAGES];
    assign sda_s     = sda_now;
    assign scl_rise  = scl_now & ~scl_old;
    assign scl_fall  = ~scl_now & scl_old;
    assign start_det = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
    import i2c_ctl_pkg::*;
#(
    parameter logic [BYTE_W-3:0] ADDR_HI = 6'b001000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              strap_i,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic [PTR_W-1:0]  reg_addr,
    output logic              idle_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [PTR_W-1:0] ONE      = PTR_W'(1);

    typedef struct packed {
        state_e            state;
        kind_e             kind;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic              rw;
        logic [BYTE_W-1:0] ptr;
        logic              drive;
        logic              wr_en;
        logic [BYTE_W-1:0] wr_data;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    always_comb begin
        logic [BYTE_W-1:0] byte_v;
        nxt_d       = cur_q;
        nxt_d.wr_en = 1'b0;
        byte_v      = {cur_q.shreg[BYTE_W-2:0], sda_s};
        if (start_det) begin
            nxt_d.state = ST_RX;
            nxt_d.kind  = K_ADDR;
            nxt_d.cnt   = '0;
            nxt_d.drive = 1'b0;
        end else if (stop_det) begin
            nxt_d.state = ST_IDLE;
            nxt_d.drive = 1'b0;
        end else begin
            case (cur_q.state)
                ST_RX: if (scl_rise) begin
                    nxt_d.shreg = byte_v;
                    nxt_d.cnt   = cur_q.cnt + 1'b1;
                    if (cur_q.cnt == LAST_BIT) begin
                        nxt_d.state = ST_ACK_WAIT;
                        case (cur_q.kind)
                            K_ADDR: begin
                                if (byte_v[BYTE_W-1:1] == {ADDR_HI, strap_i})
                                    nxt_d.rw = byte_v[0];
                                else
                                    nxt_d.state = ST_IDLE;
                            end
                            K_PTR:   nxt_d.ptr = byte_v;
                            default: begin
                                nxt_d.wr_en   = 1'b1;
                                nxt_d.wr_data = byte_v;
                            end
                        endcase
                    end
                end
                ST_ACK_WAIT: if (scl_fall) begin
                    nxt_d.drive = 1'b1;
                    nxt_d.state = ST_ACK;
                    if (cur_q.kind == K_DATA && cur_q.ptr[PTR_W])
                        nxt_d.ptr[PTR_W-1:0] = cur_q.ptr[PTR_W-1:0] + ONE;
                end
                ST_ACK: if (scl_fall) begin
                    nxt_d.cnt = '0;
                    if (cur_q.kind == K_ADDR && cur_q.rw) begin
                        nxt_d.shreg = rd_data;
                        nxt_d.drive = ~rd_data[BYTE_W-1];
                        nxt_d.state = ST_TX;
                    end else begin
                        nxt_d.drive = 1'b0;
                        nxt_d.state = ST_RX;
                        nxt_d.kind  = (cur_q.kind == K_ADDR) ? K_PTR : K_DATA;
                    end
                end
                ST_TX: if (scl_fall) begin
                    if (cur_q.cnt == LAST_BIT) begin
                        nxt_d.drive = 1'b0;
                        nxt_d.state = ST_RACK;
                        if (cur_q.ptr[PTR_W])
                            nxt_d.ptr[PTR_W-1:0] = cur_q.ptr[PTR_W-1:0] + ONE;
                    end else begin
                        nxt_d.shreg = {cur_q.shreg[BYTE_W-2:0], 1'b0};
                        nxt_d.cnt   = cur_q.cnt + 1'b1;
                        nxt_d.drive = ~cur_q.shreg[BYTE_W-2];
                    end
                end
                ST_RACK: if (scl_rise) begin
                    nxt_d.state = sda_s ? ST_IDLE : ST_RNEXT;
                end
                ST_RNEXT: if (scl_fall) begin
                    nxt_d.shreg = rd_data;
                    nxt_d.drive = ~rd_data[BYTE_W-1];
                    nxt_d.cnt   = '0;
                    nxt_d.state = ST_TX;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
            cur_q.kind  <= K_ADDR;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sda_oe   = cur_q.drive;
    assign wr_en    = cur_q.wr_en;
    assign wr_data  = cur_q.wr_data;
    assign reg_addr = cur_q.ptr[PTR_W-1:0];
    assign idle_o   = (cur_q.state == ST_IDLE);
endmodule

// File: rtl/i2c_ctl_slave.sv
module i2c_ctl_slave
    import i2c_ctl_pkg::*;
#(
    parameter logic [BYTE_W-3:0] ADDR_HI     = 6'b001000,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              strap_i,
    output logic [PTR_W-1:0]  reg_addr,
    output logic              reg_wr_en,
    output logic [BYTE_W-1:0] reg_wr_data,
    input  logic [BYTE_W-1:0] reg_rd_data
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det, fsm_idle;

    i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_byte_fsm #(.ADDR_HI(ADDR_HI)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap_i   (strap_i),
        .rd_data   (reg_rd_data),
        .sda_oe    (sda_oe),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .reg_addr  (reg_addr),
        .idle_o    (fsm_idle)
    );
endmodule

// File: rtl/i2c_ctl_chk.sv
module i2c_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic reg_wr_en,
    input logic idle
);
    // R1: outputs are quiet while reset is held
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!sda_oe && !reg_wr_en));

    // R9: the data driver only moves while the bus clock is low
    assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_i);

    // R4: each write strobe lasts one cycle
    assert_wr_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    // R4: a write strobe never coincides with the data line held low
    assert_wr_no_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !sda_oe);

    // R3: an idle (unaddressed) block leaves the line released
    assert_idle_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !sda_oe);
endmodule

bind i2c_ctl_slave i2c_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_oe    (sda_oe),
    .reg_wr_en (reg_wr_en),
    .idle      (fsm_idle)
);

// File: tb/i2c_ctl_slave_tb.sv
module i2c_ctl_slave_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       m_low = 1'b0;
    logic       strap = 1'b0;
    logic       sda_line;
    logic       sda_oe;
    logic [6:0] reg_addr;
    logic       reg_wr_en;
    logic [7:0] reg_wr_data;
    logic [7:0] reg_rd_data;

    int nchecks = 0, nerr = 0, wr_cnt = 0, r9_viol = 0;
    bit done = 1'b0, oe_seen = 1'b0, oe_prev = 1'b0;
    logic [7:0] regs [128];
    logic [6:0] log_a [64];
    logic [7:0] log_d [64];

    always #2 clk = ~clk;

    assign sda_line    = !(m_low || sda_oe);
    assign reg_rd_data = regs[reg_addr];

    i2c_ctl_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .strap_i(strap), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data)
    );

    function automatic logic [7:0] init_val(int i);
        return 8'(i) ^ 8'h5A;
    endfunction

    initial for (int i = 0; i < 128; i++) regs[i] = init_val(i);

    always @(posedge clk) if (reg_wr_en) begin
        regs[reg_addr] <= reg_wr_data;
        log_a[wr_cnt % 64] <= reg_addr;
        log_d[wr_cnt % 64] <= reg_wr_data;
        wr_cnt <= wr_cnt + 1;
    end

    always @(negedge clk) begin
        if (sda_oe) oe_seen = 1'b1;
        if (rst_n && sda_oe !== oe_prev && scl_m) r9_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hold(); repeat (10) @(negedge clk); endtask
    task automatic bus_start();  m_low = 0; scl_m = 1; hold(); m_low = 1; hold(); scl_m = 0; hold(); endtask
    task automatic bus_rstart(); m_low = 0; hold(); scl_m = 1; hold(); m_low = 1; hold(); scl_m = 0; hold(); endtask
    task automatic bus_stop();   m_low = 1; hold(); scl_m = 1; hold(); m_low = 0; hold(); endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = !b[i]; hold(); scl_m = 1; hold(); scl_m = 0; hold();
        end
        m_low = 0; hold(); scl_m = 1; hold(); ack = !sda_line; scl_m = 0; hold();
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        m_low = 0;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            hold(); scl_m = 1; hold(); b = {b[6:0], sda_line}; scl_m = 0;
        end
        m_low = give_ack; hold(); scl_m = 1; hold(); scl_m = 0; hold(); m_low = 0;
    endtask

    // {strap, 7-bit address, expected ACK}
    localparam logic [8:0] ADDR_VEC [6] = '{
        {1'b0, 7'h10, 1'b1}, {1'b0, 7'h11, 1'b0}, {1'b1, 7'h11, 1'b1},
        {1'b1, 7'h10, 1'b0}, {1'b0, 7'h50, 1'b0}, {1'b0, 7'h18, 1'b0}
    };

    initial begin
        logic ack;
        logic [7:0] rd;
        int base;
        repeat (5) @(negedge clk);
        chk("R1 oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        hold();
        chk("R1 oe after reset", sda_oe, 0);
        chk("R1 no writes", wr_cnt, 0);

        // R1/R6/R7: read at pointer 0 after reset, NACK ends it
        bus_start(); send_byte(8'h21, ack); chk("R2 read addr ack", ack, 1);
        read_byte(1'b0, rd); chk("R6 reg0 after reset", rd, init_val(0));
        chk("R7 released after NACK", sda_oe, 0);
        bus_stop();

        // R2/R3: address table
        foreach (ADDR_VEC[k]) begin
            strap = ADDR_VEC[k][8];
            hold();
            bus_start(); send_byte({ADDR_VEC[k][7:1], 1'b0}, ack);
            chk(ADDR_VEC[k][0] ? "R2 addr match" : "R3 addr mismatch", ack, ADDR_VEC[k][0]);
            bus_stop();
        end
        strap = 1'b0;
        chk("R3 no writes from address table", wr_cnt, 0);

        // R3: mismatched address, following bytes ignored
        oe_seen = 1'b0;
        bus_start(); send_byte(8'h60, ack); chk("R3 no ack", ack, 0);
        send_byte(8'h05, ack); chk("R3 ptr ignored", ack, 0);
        send_byte(8'h77, ack); chk("R3 data ignored", ack, 0);
        bus_stop();
        chk("R3 no write", wr_cnt, 0);
        chk("R3 line never driven", oe_seen, 0);

        // R4/R5: auto-increment write at index 5
        bus_start(); send_byte(8'h20, ack); chk("R2 wr addr ack", ack, 1);
        send_byte(8'h85, ack); chk("R4 ptr ack", ack, 1);
        send_byte(8'hAA, ack); chk("R4 data ack", ack, 1);
        send_byte(8'hBB, ack); chk("R4 data ack", ack, 1);
        send_byte(8'hCC, ack); chk("R4 data ack", ack, 1);
        bus_stop();
        chk("R4 write count", wr_cnt, 3);
        chk("R5 addr0", log_a[0], 5); chk("R4 data0", log_d[0], 8'hAA);
        chk("R5 addr1", log_a[1], 6); chk("R4 data1", log_d[1], 8'hBB);
        chk("R5 addr2", log_a[2], 7); chk("R4 data2", log_d[2], 8'hCC);

        // R5: fixed pointer write at index 10
        bus_start(); send_byte(8'h20, ack);
        send_byte(8'h0A, ack); send_byte(8'h11, ack); send_byte(8'h22, ack);
        bus_stop();
        chk("R5 fixed count", wr_cnt, 5);
        chk("R5 fixed addr a", log_a[3], 10);
        chk("R5 fixed addr b", log_a[4], 10);
        chk("R4 fixed data", log_d[4], 8'h22);

        // R10/R6/R7: retained fixed pointer read twice
        bus_start(); send_byte(8'h21, ack);
        read_byte(1'b1, rd); chk("R10 retained ptr read", rd, 8'h22);
        read_byte(1'b0, rd); chk("R7 second byte after ACK", rd, 8'h22);
        bus_stop();

        // R5/R6: pointer-only write then incrementing read
        base = wr_cnt;
        bus_start(); send_byte(8'h20, ack); send_byte(8'h85, ack); bus_stop();
        chk("R4 pointer-only no write", wr_cnt, base);
        bus_start(); send_byte(8'h21, ack);
        read_byte(1'b1, rd); chk("R6 read idx5", rd, 8'hAA);
        read_byte(1'b1, rd); chk("R5 read idx6", rd, 8'hBB);
        read_byte(1'b0, rd); chk("R5 read idx7", rd, 8'hCC);
        chk("R7 released", sda_oe, 0);
        bus_stop();

        // R8: repeated START switches to read at pointer 3
        bus_start(); send_byte(8'h20, ack); send_byte(8'h83, ack);
        bus_rstart(); send_byte(8'h21, ack); chk("R8 addr after rstart", ack, 1);
        read_byte(1'b0, rd); chk("R8 read after rstart", rd, init_val(3));
        bus_stop();
        chk("R8 no write in rstart", wr_cnt, base);

        chk("R9 oe stable while scl high", r9_viol, 0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchecks++; nerr++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end
endmodule